// File: doc/BRIEF.md
# Programmable Trigger Sequencer

The sequencer produces the trigger pulses that start event injection. A 2-bit mode field selects one of four behaviours. Stop generates nothing. Single gives one trigger per start strobe. Loop gives a programmed number of triggers. Non-stop repeats until the mode returns to stop. The repeat interval comes from a divider value measured in units of half the system clock rate, so with a 40 MHz clock a divider of N gives 20 MHz / N. For example, 20000 gives 1 kHz, which is one trigger every 40000 clocks.

A select input chooses between the internally sequenced triggers and an external front-panel trigger. The external signal is brought into the clock domain by a two-stage synchronizer and then edge-detected, so one external pulse gives one trigger however long it lasts. A busy input blocks the output while it is high. A trigger that falls on a busy cycle is dropped, not delayed. The output is registered and every trigger is one clock wide.

Top module: `trig_seq`

## Requirements
- R1: Mode code 2'b00 (stop) produces no internal trigger. A start strobe in this mode is ignored, and a sequence that is running ends on the first clock edge that samples 2'b00. Returning to another mode does not restart the sequence without a new strobe.
- R2: In mode 2'b01 (single), a start strobe sampled at edge k gives exactly one trigger, visible after edge k+1.
- R3: In mode 2'b10 (loop), a start strobe gives exactly `loop_cnt` triggers. The first is visible after edge k+1 and the rest follow at the programmed period. A count of zero gives no trigger.
- R4: In mode 2'b11 (non-stop), triggers repeat at the programmed period until the mode field is 2'b00.
- R5: The internal period is 2*`div_val` clocks. A `div_val` of 0 or 1 gives the fastest period of 2 clocks.
- R6: With `src_int` = 1 only internal triggers reach the output and `ext_trig` is ignored. With `src_int` = 0 only external triggers reach the output, and internal triggers are ignored.
- R7: An external trigger whose rising level is first sampled at edge a gives one trigger, visible after edge a+2. A pulse held for several clocks gives only one trigger.
- R8: A high `busy` sampled at an edge forces the output low after that edge. The blocked trigger is lost.
- R9: Every output trigger lasts exactly one clock.
- R10: A start strobe that arrives while a sequence is running is ignored and does not restart the count or the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 stop, 01 single, 10 loop, 11 non-stop |
| div_val | input | DIV_W | Period divider, in units of two clocks |
| loop_cnt | input | CNT_W | Number of triggers in loop mode |
| fire | input | 1 | Start strobe |
| src_int | input | 1 | 1 internal source, 0 external source |
| ext_trig | input | 1 | Asynchronous external trigger |
| busy | input | 1 | Blocks triggers while high |
| trig_out | output | 1 | One-clock trigger pulse |

## Verification
A start strobe sampled at edge k gives its first internal trigger one edge later, at k+1. Later triggers follow every 2*`div_val` edges. An external level change first sampled at edge a appears after edge a+2. Busy acts with no delay: it suppresses the output at the edge that samples it. The bench drives inputs on falling edges and numbers each later falling edge as a sample. Against those sample numbers it checks the position of the first trigger, every gap between triggers, the total count, and that no trigger lasts more than one sample.

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int DIV_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic [CNT_W-1:0] loop_cnt,
  input  logic             fire,
  input  logic             src_int,
  input  logic             ext_trig,
  input  logic             busy,
  output logic             trig_out
);
  localparam logic [1:0] M_STOP = 2'b00;
  localparam logic [1:0] M_ONE  = 2'b01;
  localparam logic [1:0] M_LOOP = 2'b10;
  localparam logic [1:0] M_FREE = 2'b11;
  localparam int TW = DIV_W + 1;

  logic           s1, s2, s3;
  logic           run;
  logic [TW-1:0]  tmr;
  logic [CNT_W-1:0] left;
  logic           trig_q;

  wire [TW-1:0] per_m1 = (div_val <= DIV_W'(1)) ? TW'(1) : ({div_val, 1'b0} - TW'(1));
  wire hit      = run && (mode != M_STOP) && (tmr == '0);
  wire last     = (mode != M_FREE) && (left == CNT_W'(1));
  wire ext_rise = s2 & ~s3;
  wire can_go   = fire && (mode != M_STOP) && ((mode != M_LOOP) || (loop_cnt != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s3, s2, s1} <= '0;
      run    <= 1'b0;
      tmr    <= '0;
      left   <= '0;
      trig_q <= 1'b0;
    end else begin
      {s3, s2, s1} <= {s2, s1, ext_trig};
      if (mode == M_STOP) begin
        run <= 1'b0;
      end else if (!run) begin
        if (can_go) begin
          run  <= 1'b1;
          tmr  <= '0;
          left <= (mode == M_ONE) ? CNT_W'(1) : loop_cnt;
        end
      end else if (hit) begin
        tmr  <= per_m1;
        left <= left - CNT_W'(1);
        if (last) run <= 1'b0;
      end else begin
        tmr <= tmr - TW'(1);
      end
      trig_q <= (src_int ? hit : ext_rise) & ~busy;
    end
  end

  assign trig_out = trig_q;

  p_stop_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STOP && src_int) |=> !trig_out);
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STOP) |=> !run);
  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
  p_ext_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && !$past(src_int)) |-> $past(ext_trig, 3));
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !trig_out);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);
endmodule

// File: tb/sim_trig_seq.sv
module sim_trig_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] div_val = '0;
  logic [15:0] loop_cnt = '0;
  logic        fire = 1'b0, src_int = 1'b1, ext_trig = 1'b0, busy = 1'b0;
  logic        trig_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  trig_seq u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .div_val(div_val),
    .loop_cnt(loop_cnt), .fire(fire), .src_int(src_int), .ext_trig(ext_trig),
    .busy(busy), .trig_out(trig_out));

  localparam int NV = 9;
  localparam int V_MODE [NV] = '{1, 2, 2, 2, 2, 2, 3, 3, 2};
  localparam int V_DIV  [NV] = '{5, 3, 0, 1, 2, 7, 4, 0, 20000};
  localparam int V_CNT  [NV] = '{9, 4, 5, 3, 3, 0, 0, 0, 2};
  localparam int V_WIN  [NV] = '{40, 60, 30, 30, 30, 40, 40, 11, 40010};
  localparam int V_NUM  [NV] = '{1, 4, 5, 3, 3, 0, 5, 6, 2};
  localparam int V_GAP  [NV] = '{0, 6, 2, 2, 4, 0, 8, 2, 40000};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int n_seen, first_at, bad_gap, wide;
  task automatic observe(input int win, input int gap);
    int last_at;
    bit prev;
    n_seen = 0; first_at = 0; bad_gap = 0; wide = 0; last_at = 0; prev = 1'b0;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (trig_out) begin
        if (prev) wide++;
        if (n_seen == 0) first_at = i;
        else if (gap != 0 && i - last_at != gap) bad_gap++;
        last_at = i;
        n_seen++;
      end
      prev = trig_out;
    end
  endtask

  task automatic strobe;
    @(negedge clk); fire = 1'b1;
    @(negedge clk); fire = 1'b0;
  endtask

  task automatic idle;
    mode = 2'b00;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(trig_out == 1'b0, "R9 reset", trig_out, 0);
    rst_n = 1'b1;

    // Table: R2 single, R3 loop, R4 non-stop, R5 period
    for (int v = 0; v < NV; v++) begin
      mode = V_MODE[v][1:0]; div_val = V_DIV[v]; loop_cnt = V_CNT[v]; src_int = 1'b1;
      strobe();
      observe(V_WIN[v], V_GAP[v]);
      chk(n_seen == V_NUM[v], "R2/R3/R4 count", n_seen, V_NUM[v]);
      if (V_NUM[v] > 0) chk(first_at == 1, "R2 first latency", first_at, 1);
      chk(bad_gap == 0, "R5 period", bad_gap, 0);
      chk(wide == 0, "R9 width", wide, 0);
      if (V_MODE[v] == 3) begin
        mode = 2'b00;
        observe(40, 0);
        chk(n_seen == 0, "R4 stops on 00", n_seen, 0);
      end
      idle();
    end

    // R1: strobe in stop mode ignored
    mode = 2'b00; div_val = 1;
    strobe(); observe(20, 0);
    chk(n_seen == 0, "R1 strobe in stop", n_seen, 0);

    // R1: loop aborted by stop, not resumed without strobe
    mode = 2'b10; div_val = 2; loop_cnt = 10;
    strobe(); observe(6, 4);
    chk(n_seen == 2, "R1 before abort", n_seen, 2);
    mode = 2'b00; observe(20, 0);
    chk(n_seen == 0, "R1 after abort", n_seen, 0);
    mode = 2'b10; observe(20, 0);
    chk(n_seen == 0, "R1 no resume", n_seen, 0);
    idle();

    // R10: second strobe while running ignored
    mode = 2'b10; div_val = 10; loop_cnt = 2;
    strobe();
    fork
      begin repeat (5) @(negedge clk); fire = 1'b1; @(negedge clk); fire = 1'b0; end
      observe(60, 20);
    join
    chk(n_seen == 2, "R10 count", n_seen, 2);
    chk(bad_gap == 0, "R10 period kept", bad_gap, 0);
    idle();

    // R6: internal ignored when external selected
    src_int = 1'b0; mode = 2'b11; div_val = 1;
    strobe(); observe(20, 0);
    chk(n_seen == 0, "R6 internal masked", n_seen, 0);
    idle();

    // R7: external long pulse -> one trigger, three edges later
    src_int = 1'b0;
    @(negedge clk); ext_trig = 1'b1;
    fork
      begin repeat (5) @(negedge clk); ext_trig = 1'b0; end
      observe(20, 0);
    join
    chk(n_seen == 1, "R7 one trigger", n_seen, 1);
    chk(first_at == 3, "R7 latency", first_at, 3);

    // R6: external ignored when internal selected
    src_int = 1'b1;
    @(negedge clk); ext_trig = 1'b1;
    fork
      begin repeat (3) @(negedge clk); ext_trig = 1'b0; end
      observe(12, 0);
    join
    chk(n_seen == 0, "R6 external masked", n_seen, 0);

    // R8: busy blocks, then release resumes
    mode = 2'b11; div_val = 1; busy = 1'b1;
    strobe(); observe(10, 0);
    chk(n_seen == 0, "R8 busy blocks", n_seen, 0);
    busy = 1'b0; observe(10, 2);
    chk(n_seen == 5, "R8 resume", n_seen, 5);
    chk(bad_gap == 0 && wide == 0, "R9 after busy", bad_gap + wide, 0);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule